// File: doc/BRIEF.md
# Shared Byte Command Register File

This block is a small configuration store of byte-wide registers that several serial byte links can reach at once. Each link is modelled here as a byte stream. Received bytes arrive on a valid/ready pair, and read results leave as a one-cycle transmit pulse with its byte. The serial cores that produce and consume those bytes sit outside this block.

Every command on a link has two bytes. The first byte carries a direction flag in bit 7 and a register address in bits 6:0. On a write, the second byte is stored. On a read, the register is fetched and handed to the link's transmit side. Links that prepend a framing byte to each transfer, such as a bus whose slave-address byte is also delivered, can be told to discard one leading byte per command. A fixed-priority arbiter lets one link use the shared register port per cycle. The low bits of the first few registers drive configuration outputs.

Back-pressure works as follows. A link's `rx_ready` is high while its decoder waits for a header or an address byte. While the decoder waits for a write data byte, `rx_ready` rises only in the cycle its request is granted. It stays low while a read is waiting for the register port. A byte is taken only on a clock edge where valid and ready are both high. A sender must hold valid and data steady until that edge.

Top module: `cfgrf_top`

## Requirements
- R1: In the first command byte, bit 7 selects the operation (0 = write, 1 = read) and bits 6:0 carry the register address.
- R2: On a write, the byte accepted after the address byte is stored in the addressed register.
- R3: Address bits at and above AW are ignored. With AW=4, address 0x73 reaches register 3.
- R4: On a read, the full 8-bit register value appears on the link's `tx_data` byte, with `tx_valid` high for exactly one cycle. This happens one cycle after the read is granted, which is two cycles after the address byte when there is no contention.
- R5: At most one link is granted per cycle. Link 0 wins over link 1, and link 1 wins over link 2. A grant goes only to a requesting link.
- R6: A link whose bit is set in SKIP_MASK discards the first byte of every command. By default only link 0 does this.
- R7: After a command completes, and after reset, a decoder again waits for the start of a new command.
- R8: On reset, register i takes byte i of RST_VAL. By default that value is 0xA0+i.
- R9: `cfg_o` holds the low CFG_W bits of registers 0 to NCFG-1, with register 0 in the lowest field. It changes only after a register write.
- R10: A byte is consumed only when valid and ready are both high. A link that loses arbitration for a write data byte sees `rx_ready` low until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | NP | Per-link received byte valid |
| rx_ready | output | NP | Per-link received byte ready |
| rx_data | input | NP*8 | Per-link received byte, link i in bits 8i+7:8i |
| tx_valid | output | NP | Per-link one-cycle transmit load pulse |
| tx_data | output | NP*8 | Per-link transmit byte |
| cfg_o | output | NCFG*CFG_W | Exported low bits of registers 0..NCFG-1 |

## Verification
The assertions assume that a link never has a second read result pending before its first one has been issued. This follows from the protocol, since each read needs a fresh address byte. They also assume that reset is applied before the first use. The bench drives each link through a task that raises valid at a falling edge, keeps it raised until ready is seen, and drops it after one accepting edge, so the handshake is always respected. Random commands go one at a time. Only the directed arbitration case presents two links in the same cycle.

// File: rtl/cfgrf_pkg.sv
package cfgrf_pkg;
  typedef enum logic [1:0] {
    ST_SKIP = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_READ = 2'd3
  } dec_state_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/cfgrf_cmd_decoder.sv
module cfgrf_cmd_decoder
  import cfgrf_pkg::*;
#(
  parameter int unsigned AW       = 4,
  parameter bit          SKIP_HDR = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              req,
  input  logic              gnt,
  output logic              wr,
  output logic [AW-1:0]     addr,
  output logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data
);
  localparam dec_state_e IDLE_ST = SKIP_HDR ? ST_SKIP : ST_ADDR;

  dec_state_e      state;
  logic [AW-1:0]   addr_q;

  always_comb begin
    req      = ((state == ST_DATA) && rx_valid) || (state == ST_READ);
    rx_ready = (state == ST_SKIP) || (state == ST_ADDR) ||
               ((state == ST_DATA) && gnt);
    wr       = (state == ST_DATA) && rx_valid && gnt;
    addr     = addr_q;
    wdata    = rx_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= IDLE_ST;
      addr_q   <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= 1'b0;
      unique case (state)
        ST_SKIP: if (rx_valid) state <= ST_ADDR;
        ST_ADDR: if (rx_valid) begin
          addr_q <= rx_data[AW-1:0];
          state  <= rx_data[BYTE_W-1] ? ST_READ : ST_DATA;
        end
        ST_DATA: if (rx_valid && gnt) state <= IDLE_ST;
        ST_READ: if (gnt) begin
          tx_data  <= rd_data;
          tx_valid <= 1'b1;
          state    <= IDLE_ST;
        end
        default: state <= IDLE_ST;
      endcase
    end
  end
endmodule

// File: rtl/cfgrf_prio_arb.sv
module cfgrf_prio_arb #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  always_comb begin
    gnt = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfgrf_store.sv
module cfgrf_store
  import cfgrf_pkg::*;
#(
  parameter int unsigned AW    = 4,
  parameter int unsigned NCFG  = 8,
  parameter int unsigned CFG_W = 3,
  parameter logic [(2**AW)*BYTE_W-1:0] RST_VAL = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [AW-1:0]         addr,
  input  logic [BYTE_W-1:0]     wdata,
  output logic [BYTE_W-1:0]     rdata,
  output logic [NCFG*CFG_W-1:0] cfg_o
);
  localparam int unsigned NREG = 2 ** AW;

  logic [BYTE_W-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= RST_VAL[i*BYTE_W +: BYTE_W];
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    assign cfg_o[g*CFG_W +: CFG_W] = mem[g][CFG_W-1:0];
  end
endmodule

// File: rtl/cfgrf_top.sv
module cfgrf_top
  import cfgrf_pkg::*;
#(
  parameter int unsigned NP        = 3,
  parameter int unsigned SKIP_MASK = 1,
  parameter int unsigned AW        = 4,
  parameter int unsigned NCFG      = 8,
  parameter int unsigned CFG_W     = 3,
  parameter logic [(2**AW)*8-1:0] RST_VAL =
    128'hAFAEADACABAAA9A8A7A6A5A4A3A2A1A0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NP-1:0]         rx_valid,
  output logic [NP-1:0]         rx_ready,
  input  logic [NP*8-1:0]       rx_data,
  output logic [NP-1:0]         tx_valid,
  output logic [NP*8-1:0]       tx_data,
  output logic [NCFG*CFG_W-1:0] cfg_o
);
  logic [NP-1:0]     req;
  logic [NP-1:0]     gnt;
  logic [NP-1:0]     wr;
  logic [AW-1:0]     addr_v  [NP];
  logic [BYTE_W-1:0] wdata_v [NP];
  logic [AW-1:0]     sel_addr;
  logic [BYTE_W-1:0] sel_wdata;
  logic [BYTE_W-1:0] rd_data;
  logic              wr_any;

  for (genvar p = 0; p < NP; p++) begin : g_port
    cfgrf_cmd_decoder #(
      .AW       (AW),
      .SKIP_HDR (((SKIP_MASK >> p) & 1) != 0)
    ) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_valid (rx_valid[p]),
      .rx_ready (rx_ready[p]),
      .rx_data  (rx_data[p*8 +: 8]),
      .req      (req[p]),
      .gnt      (gnt[p]),
      .wr       (wr[p]),
      .addr     (addr_v[p]),
      .wdata    (wdata_v[p]),
      .rd_data  (rd_data),
      .tx_valid (tx_valid[p]),
      .tx_data  (tx_data[p*8 +: 8])
    );
  end

  cfgrf_prio_arb #(.N(NP)) u_arb (
    .req (req),
    .gnt (gnt)
  );

  always_comb begin
    sel_addr  = '0;
    sel_wdata = '0;
    for (int i = 0; i < NP; i++) begin
      if (gnt[i]) begin
        sel_addr  = addr_v[i];
        sel_wdata = wdata_v[i];
      end
    end
    wr_any = |(wr & gnt);
  end

  cfgrf_store #(
    .AW      (AW),
    .NCFG    (NCFG),
    .CFG_W   (CFG_W),
    .RST_VAL (RST_VAL)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_any),
    .addr  (sel_addr),
    .wdata (sel_wdata),
    .rdata (rd_data),
    .cfg_o (cfg_o)
  );
endmodule

// File: rtl/cfgrf_checker.sv
module cfgrf_checker #(
  parameter int unsigned NP    = 3,
  parameter int unsigned NCFG  = 8,
  parameter int unsigned CFG_W = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NP-1:0]         req,
  input logic [NP-1:0]         gnt,
  input logic                  wr_any,
  input logic [NP-1:0]         tx_valid,
  input logic [NCFG*CFG_W-1:0] cfg_o
);
  assert_grant_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  assert_grant_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

  assert_top_priority_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req[0] |-> gnt[0]);

  if (NP > 1) begin : g_second
    assert_second_priority_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req[1] && !req[0]) |-> gnt[1]);
  end

  // R4: a load pulse never lasts two cycles on any link
  assert_tx_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|tx_valid) |=> ((tx_valid & $past(tx_valid)) == '0));

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_any |=> $stable(cfg_o));
endmodule

bind cfgrf_top cfgrf_checker #(
  .NP    (NP),
  .NCFG  (NCFG),
  .CFG_W (CFG_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req      (req),
  .gnt      (gnt),
  .wr_any   (wr_any),
  .tx_valid (tx_valid),
  .cfg_o    (cfg_o)
);

// File: tb/tb_cfgrf_top.sv
module tb_cfgrf_top;
  localparam int NP = 3, AW = 4, NREG = 16, NCFG = 8, CFG_W = 3;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [NP-1:0]         rx_valid = '0;
  logic [NP-1:0]         rx_ready;
  logic [NP*8-1:0]       rx_data = '0;
  logic [NP-1:0]         tx_valid;
  logic [NP*8-1:0]       tx_data;
  logic [NCFG*CFG_W-1:0] cfg_o;

  int nchk = 0, nfail = 0;
  logic [7:0] mdl [NREG];

  always #5 clk = ~clk;

  cfgrf_top dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .tx_valid(tx_valid), .tx_data(tx_data), .cfg_o(cfg_o)
  );

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [NCFG*CFG_W-1:0] exp_cfg();
    logic [NCFG*CFG_W-1:0] v;
    for (int i = 0; i < NCFG; i++) v[i*CFG_W +: CFG_W] = mdl[i][CFG_W-1:0];
    return v;
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < NREG; i++) mdl[i] = 8'hA0 + 8'(i);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    rx_valid = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic send_byte(int p, logic [7:0] b);
    @(negedge clk);
    rx_valid[p] = 1'b1;
    rx_data[p*8 +: 8] = b;
    #1;
    while (!rx_ready[p]) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    rx_valid[p] = 1'b0;
  endtask

  task automatic do_write(int p, logic [6:0] a, logic [7:0] d);
    if (p == 0) send_byte(p, 8'h4A);        // R6: header byte discarded
    send_byte(p, {1'b0, a});                // R1: bit 7 = 0 write
    send_byte(p, d);
    mdl[a[AW-1:0]] = d;                     // R3: truncated address
    #1;
    chk("R9 cfg after write", 32'(cfg_o), 32'(exp_cfg()));
  endtask

  task automatic do_read(int p, logic [6:0] a, string rq);
    int waited = 0;
    if (p == 0) send_byte(p, 8'h4A);
    send_byte(p, {1'b1, a});                // R1: bit 7 = 1 read
    while (!tx_valid[p] && waited < 10) begin
      @(negedge clk);
      waited++;
    end
    chk("R4 tx_valid seen", 32'(tx_valid[p]), 32'd1);
    chk("R4 read latency", 32'(waited), 32'd1);
    chk(rq, 32'(tx_data[p*8 +: 8]), 32'(mdl[a[AW-1:0]]));
    @(negedge clk);
    chk("R4 pulse one cycle", 32'(tx_valid[p]), 32'd0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = $urandom(32'd2024);
    do_reset();
    #1;
    // R8 reset defaults, R7 idle after reset
    chk("R8 cfg defaults", 32'(cfg_o), 32'(exp_cfg()));
    chk("R7 ready after reset", 32'(rx_ready), 32'b111);
    chk("R4 no tx at reset", 32'(tx_valid), 32'd0);
    for (int i = 0; i < NREG; i++) do_read(1, 7'(i), "R8 default readback");

    // R2 / R4 full byte retained although only low bits exported
    do_write(1, 7'h02, 8'hF5);
    do_read(2, 7'h02, "R4 full byte readback");
    // R3 upper address bits ignored
    do_write(2, 7'h73, 8'h3C);
    do_read(1, 7'h03, "R3 truncated write");
    do_read(0, 7'h53, "R3 truncated read");
    // R6 header skip on link 0: header 0x4A must not become an address
    do_write(0, 7'h07, 8'h66);
    do_read(0, 7'h07, "R6 skip header");
    do_read(1, 7'h0A, "R6 reg10 untouched");

    // R5 / R10 arbitration between link 0 and link 2 on write data
    send_byte(0, 8'h4A);
    send_byte(0, 8'h05);
    send_byte(2, 8'h05);
    @(negedge clk);
    rx_valid[0] = 1'b1; rx_data[7:0]   = 8'h11;
    rx_valid[2] = 1'b1; rx_data[23:16] = 8'h22;
    #1;
    chk("R5 link0 wins", 32'(rx_ready), 32'b011);
    @(negedge clk);
    rx_valid[0] = 1'b0;
    #1;
    chk("R10 link2 granted after", 32'(rx_ready[2]), 32'd1);
    @(negedge clk);
    rx_valid[2] = 1'b0;
    mdl[5] = 8'h22;
    do_read(1, 7'h05, "R5 lower priority writes last");

    // R7 reset mid-command: next address byte must be taken as a command
    send_byte(1, 8'h09);
    do_reset();
    do_read(1, 7'h09, "R7 decoder restarted by reset");
    #1;
    chk("R8 cfg after reset", 32'(cfg_o), 32'(exp_cfg()));

    // Random commands
    for (int n = 0; n < 300; n++) begin
      int p;
      logic [6:0] a;
      logic [7:0] d;
      p = int'($urandom % NP);
      a = 7'($urandom);
      d = 8'($urandom);
      if ($urandom % 2) do_write(p, a, d);
      else              do_read(p, a, "R2 random readback");
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule